// File: doc/BRIEF.md
# I2C Target with 16-bit Register Bank

This block is an I2C target that gives a serial controller access to a bank of 32 registers, each 16 bits wide. It oversamples the bus lines on the system clock, passes both through two-flop synchronisers, and pulls SDA low through an open-drain enable. The block holds no storage of its own. It drives an index, write data and a one-cycle write strobe towards an external register file, and it reads that file's combinational read data.

To write a register, the controller addresses the target in write direction. It then sends an index byte, followed by the high data byte and the low data byte. To read a register, the controller first sets the index in a write-direction transfer. It then addresses the target in read direction and clocks out two bytes. That second transfer may begin with a repeated START, or with a STOP followed by a new START. The index is held until it is overwritten, so either form works.

Top module: `i2c_reg16_target`

## Requirements
- R1: The target acknowledges the address byte 0xAC (7-bit address 0x56, bit 0 = 0, write direction) and 0xAD (bit 0 = 1, read direction) by pulling SDA low in the ninth clock.
- R2: After an address byte with any other 7-bit address, the target acknowledges nothing, keeps SDA released until the next START, and produces no write strobe.
- R3: In a write-direction transfer, the first byte after the address is the index. The low five bits select the register, and reg_addr presents this index from the following clock on.
- R4: The first data byte is bits 15:8 and the second is bits 7:0. Exactly one reg_we pulse, one cycle long with reg_wdata = {first, second}, follows the acknowledge of the second data byte.
- R5: A write transfer that ends after one data byte leaves the register unchanged.
- R6: The target acknowledges data bytes beyond the second in a write-direction transfer and discards them without a further write.
- R7: In a read-direction transfer, the target sends bits 15:8 and then bits 7:0 of the indexed register, most significant bit first.
- R8: The index is kept across a STOP, so a read that starts with STOP plus START returns the register selected earlier.
- R9: When the controller answers a sent byte with NACK, the target releases SDA and stays released until the next START.
- R10: If the controller acknowledges the second read byte, every further byte it reads is 0xFF.
- R11: After reset, sda_oe and reg_we are 0 and reg_addr is 0. SDA is only ever changed by the target while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| reg_addr | output | 5 | Register index held by the target |
| reg_wdata | output | 16 | Data for the register write |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 16 | Read data of the register at reg_addr |

## Verification
The hardest states to reach are the ones where the controller breaks off a transfer partway through. These are a STOP after one data byte, a NACK after the first read byte, and a read that follows a STOP instead of a repeated START. In each, the target must give up a partly built byte or a driven line without losing the stored index. The bench drives the bus bit by bit from small controller tasks (start, repeated start, stop, send byte, receive byte with a chosen answer). Chaining these tasks in non-standard orders places each abort at an exact bit. The bench then reads the affected register back through the normal protocol.

// File: rtl/i2c_rp_pkg.sv
package i2c_rp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_A,
    ST_RX,
    ST_ACK_R,
    ST_TX,
    ST_ACK_T
  } rp_state_t;

  // address byte matches the device when its upper seven bits equal it
  function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] dev);
    return b[7:1] == dev;
  endfunction

  // bit 0 of the address byte: 1 = target sends
  function automatic logic is_read(input logic [7:0] b);
    return b[0];
  endfunction

endpackage

// File: rtl/i2c_rp_sync.sv
module i2c_rp_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] din,
  output logic [LINES-1:0] dout
);
  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], din[l]};
    end
    assign dout[l] = chain[STAGES-1];
  end
endmodule

// File: rtl/i2c_rp_cond.sv
module i2c_rp_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_evt,
  output logic stop_evt,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
endmodule

// File: rtl/i2c_rp_engine.sv
module i2c_rp_engine
  import i2c_rp_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h56,
  parameter int         REG_AW   = 5,
  parameter int         REG_DW   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  output logic              sda_oe,
  output logic [REG_AW-1:0] ptr,
  output logic [REG_DW-1:0] wdata,
  output logic              we,
  input  logic [REG_DW-1:0] rdata,
  output rp_state_t         state
);
  localparam int BYTES = REG_DW / 8;
  localparam int IW    = $clog2(BYTES + 3);
  localparam logic [IW-1:0] IDX_WR   = IW'(BYTES + 1);
  localparam logic [IW-1:0] IDX_DONE = IW'(BYTES + 2);

  logic [3:0]        cnt;
  logic [7:0]        sh;
  logic              rw;
  logic              ack_ok;
  logic [IW-1:0]     rx_idx;
  logic [REG_DW-1:0] wbuf;
  logic [REG_DW-1:0] txbuf;
  logic [7:0]        txbyte;

  // next word of the send buffer: one byte consumed, ones shifted in
  function automatic logic [REG_DW-1:0] tx_advance(input logic [REG_DW-1:0] b);
    return {b[REG_DW-9:0], 8'hFF};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      sh     <= '0;
      rw     <= 1'b0;
      ack_ok <= 1'b0;
      rx_idx <= '0;
      wbuf   <= '0;
      txbuf  <= '0;
      txbyte <= '0;
      sda_oe <= 1'b0;
      ptr    <= '0;
      wdata  <= '0;
      we     <= 1'b0;
    end else begin
      we <= 1'b0;
      if (start_evt) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        rx_idx <= '0;
        sda_oe <= 1'b0;
      end else if (stop_evt) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: ;
          ST_ADDR: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (addr_hit(sh, DEV_ADDR)) begin
                sda_oe <= 1'b1;
                rw     <= is_read(sh);
                state  <= ST_ACK_A;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ACK_A: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                txbyte <= rdata[REG_DW-1 -: 8];
                txbuf  <= tx_advance(rdata);
                sda_oe <= ~rdata[REG_DW-1];
                state  <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_RX;
              end
            end
          end
          ST_RX: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              sda_oe <= 1'b1;
              cnt    <= '0;
              state  <= ST_ACK_R;
              if (rx_idx == '0) ptr <= sh[REG_AW-1:0];
              else if (rx_idx < IDX_WR) wbuf <= {wbuf[REG_DW-9:0], sh};
              if (rx_idx < IDX_WR) rx_idx <= rx_idx + 1'b1;
            end
          end
          ST_ACK_R: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= ST_RX;
              if (rx_idx == IDX_WR) begin
                we     <= 1'b1;
                wdata  <= wbuf;
                rx_idx <= IDX_DONE;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                sda_oe <= 1'b0;
                state  <= ST_ACK_T;
              end else begin
                cnt    <= cnt + 4'd1;
                txbyte <= {txbyte[6:0], 1'b1};
                sda_oe <= ~txbyte[6];
              end
            end
          end
          ST_ACK_T: begin
            if (scl_rise) begin
              ack_ok <= ~sda_s;
            end else if (scl_fall) begin
              if (ack_ok) begin
                txbyte <= txbuf[REG_DW-1 -: 8];
                txbuf  <= tx_advance(txbuf);
                sda_oe <= ~txbuf[REG_DW-1];
                cnt    <= '0;
                state  <= ST_TX;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_reg16_target.sv
module i2c_reg16_target
  import i2c_rp_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h56,
  parameter int         REG_AW      = 5,
  parameter int         REG_DW      = 16,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [REG_AW-1:0] reg_addr,
  output logic [REG_DW-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [REG_DW-1:0] reg_rdata
);
  logic [1:0] lines_s;
  logic       scl_s, sda_s;
  logic       start_evt, stop_evt, scl_rise, scl_fall;
  rp_state_t  state;
  logic       st_idle;

  i2c_rp_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({scl_i, sda_i}),
    .dout (lines_s)
  );
  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  i2c_rp_cond u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .start_evt(start_evt),
    .stop_evt (stop_evt),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall)
  );

  i2c_rp_engine #(.DEV_ADDR(DEV_ADDR), .REG_AW(REG_AW), .REG_DW(REG_DW)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_evt(start_evt),
    .stop_evt (stop_evt),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .sda_s    (sda_s),
    .sda_oe   (sda_oe),
    .ptr      (reg_addr),
    .wdata    (reg_wdata),
    .we       (reg_we),
    .rdata    (reg_rdata),
    .state    (state)
  );

  assign st_idle = (state == ST_IDLE);
endmodule

// File: rtl/i2c_reg16_target_chk.sv
module i2c_reg16_target_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          start_evt,
  input logic          stop_evt,
  input logic          st_idle,
  input logic          sda_oe,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr
);
  // R4: the write strobe lasts a single cycle
  assert_we_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R4: the write lands at the end of the acknowledge clock, with SCL low
  assert_we_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> !scl_s);

  // R11: SDA drive changes only while SCL is low
  assert_oe_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  // R2 / R9: an idle target never pulls SDA
  assert_idle_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    st_idle |-> !sda_oe);

  // R8: a STOP leaves the index untouched
  assert_ptr_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> $stable(reg_addr));

  // R11: after STOP the line is released
  assert_stop_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);

  // R2: a START never coincides with a write strobe on the next cycle
  assert_start_no_we_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !reg_we);
endmodule

bind i2c_reg16_target i2c_reg16_target_chk #(.AW(REG_AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_s    (scl_s),
  .start_evt(start_evt),
  .stop_evt (stop_evt),
  .st_idle  (st_idle),
  .sda_oe   (sda_oe),
  .reg_we   (reg_we),
  .reg_addr (reg_addr)
);

// File: tb/i2c_reg16_target_tb.sv
`timescale 1ns/1ps
module i2c_reg16_target_tb;
  localparam int H = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_ctl = 1'b1;
  logic        sda_ctl = 1'b1;
  logic        sda_oe;
  logic        sda_line;
  logic [4:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic        reg_we;
  logic [15:0] reg_rdata;

  logic [15:0] rf  [32];
  logic [15:0] exp_rf [32];
  int          we_cnt = 0;
  int          oe_viol = 0;
  int          checks = 0;
  int          errors = 0;

  always #2.5 clk = ~clk;

  assign sda_line  = sda_ctl & ~sda_oe;
  assign reg_rdata = rf[reg_addr];

  i2c_reg16_target u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_ctl),
    .sda_i    (sda_line),
    .sda_oe   (sda_oe),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_we   (reg_we),
    .reg_rdata(reg_rdata)
  );

  // external register file
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) rf[i] <= 16'(i * 16'h0101);
    end else if (reg_we) begin
      rf[reg_addr] <= reg_wdata;
      we_cnt <= we_cnt + 1;
    end
  end

  // R11 monitor: the drive must not change while the bus clock is high
  logic oe_prev = 1'b0;
  always @(posedge clk) begin
    if (rst_n && scl_ctl && sda_oe != oe_prev) oe_viol <= oe_viol + 1;
    oe_prev <= sda_oe;
  end

  localparam logic [23:0] VEC [8] = '{
    24'h00_A5C3, 24'h1F_8001, 24'h05_7FFE, 24'h10_FFFF,
    24'h0A_0000, 24'h01_1234, 24'h1E_BEEF, 24'h05_0F0F
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic hstep();
    repeat (H) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_ctl = 1'b1; scl_ctl = 1'b1; hstep();
    sda_ctl = 1'b0; hstep();
    scl_ctl = 1'b0; hstep();
  endtask

  task automatic bus_rstart();
    sda_ctl = 1'b1; hstep();
    scl_ctl = 1'b1; hstep();
    sda_ctl = 1'b0; hstep();
    scl_ctl = 1'b0; hstep();
  endtask

  task automatic bus_stop();
    sda_ctl = 1'b0; hstep();
    scl_ctl = 1'b1; hstep();
    sda_ctl = 1'b1; hstep();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_ctl = b[i]; hstep();
      scl_ctl = 1'b1; hstep();
      scl_ctl = 1'b0;
    end
    sda_ctl = 1'b1; hstep();
    scl_ctl = 1'b1;
    repeat (H/2) @(negedge clk);
    acked = ~sda_line;
    repeat (H/2) @(negedge clk);
    scl_ctl = 1'b0;
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    sda_ctl = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hstep();
      scl_ctl = 1'b1;
      repeat (H/2) @(negedge clk);
      b[i] = sda_line;
      repeat (H/2) @(negedge clk);
      scl_ctl = 1'b0;
    end
    sda_ctl = nack; hstep();
    scl_ctl = 1'b1; hstep();
    scl_ctl = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] p, input logic [15:0] d, input string req);
    logic a0, a1, a2, a3;
    bus_start();
    send_byte(8'hAC, a0);
    send_byte(p, a1);
    send_byte(d[15:8], a2);
    send_byte(d[7:0], a3);
    bus_stop();
    chk({req, " write acks"}, {a0, a1, a2, a3}, 4'hF);
  endtask

  task automatic do_read(input logic [7:0] p, input logic via_stop, output logic [15:0] d);
    logic a0, a1, a2;
    logic [7:0] hi, lo;
    bus_start();
    send_byte(8'hAC, a0);
    send_byte(p, a1);
    if (via_stop) begin bus_stop(); bus_start(); end
    else bus_rstart();
    send_byte(8'hAD, a2);
    recv_byte(1'b0, hi);
    recv_byte(1'b1, lo);
    bus_stop();
    chk("R1 read-path acks", {a0, a1, a2}, 3'b111);
    d = {hi, lo};
  endtask

  initial begin
    logic [15:0] rd;
    logic [7:0]  b;
    logic        a, a1, a2;
    int          lows;
    int          wc;

    for (int i = 0; i < 32; i++) exp_rf[i] = 16'(i * 16'h0101);
    repeat (5) @(negedge clk);
    // R11: reset state
    chk("R11 reset sda_oe", sda_oe, 0);
    chk("R11 reset reg_we", reg_we, 0);
    chk("R11 reset reg_addr", reg_addr, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // table of writes, each read back with a repeated START
    for (int v = 0; v < 8; v++) begin
      wc = we_cnt;
      do_write(VEC[v][23:16], VEC[v][15:0], "R1");
      exp_rf[VEC[v][20:16]] = VEC[v][15:0];
      chk("R4 one strobe per write", we_cnt - wc, 1);
      chk("R3 index on reg_addr", reg_addr, VEC[v][20:16]);
      do_read(VEC[v][23:16], 1'b0, rd);
      chk("R7 read back hi/lo", rd, exp_rf[VEC[v][20:16]]);
    end

    // R3: upper bits of the index byte do not select
    do_write(8'h27, 16'h5AA5, "R3");
    exp_rf[7] = 16'h5AA5;
    chk("R3 low five bits index", reg_addr, 7);
    chk("R3 register 7 written", rf[7], 16'h5AA5);

    // R2: foreign address
    wc = we_cnt;
    bus_start();
    send_byte(8'hB4, a);
    chk("R2 foreign address not acked", a, 0);
    send_byte(8'h03, a1);
    send_byte(8'h11, a2);
    chk("R2 later bytes not acked", {a1, a2}, 0);
    bus_stop();
    chk("R2 no write strobe", we_cnt - wc, 0);

    // R5: one data byte then STOP
    wc = we_cnt;
    bus_start();
    send_byte(8'hAC, a);
    send_byte(8'h03, a);
    send_byte(8'hEE, a);
    bus_stop();
    chk("R5 no strobe on short write", we_cnt - wc, 0);
    do_read(8'h03, 1'b0, rd);
    chk("R5 register unchanged", rd, exp_rf[3]);

    // R6: extra data bytes
    wc = we_cnt;
    bus_start();
    send_byte(8'hAC, a);
    send_byte(8'h04, a);
    send_byte(8'hC0, a);
    send_byte(8'hDE, a);
    send_byte(8'h12, a1);
    send_byte(8'h34, a2);
    bus_stop();
    exp_rf[4] = 16'hC0DE;
    chk("R6 extra bytes acked", {a1, a2}, 2'b11);
    chk("R6 single strobe", we_cnt - wc, 1);
    chk("R6 register holds first pair", rf[4], 16'hC0DE);

    // R8: index set, STOP, fresh START read
    do_read(8'h1F, 1'b1, rd);
    chk("R8 read after STOP+START", rd, exp_rf[31]);

    // R10: third byte read is all ones
    bus_start();
    send_byte(8'hAD, a);
    recv_byte(1'b0, b);
    chk("R10 first byte", b, exp_rf[31][15:8]);
    recv_byte(1'b0, b);
    chk("R10 second byte", b, exp_rf[31][7:0]);
    recv_byte(1'b1, b);
    chk("R10 filler byte", b, 8'hFF);
    bus_stop();

    // R9: NACK after first byte releases the line
    bus_start();
    send_byte(8'hAD, a);
    chk("R1 read address acked", a, 1);
    recv_byte(1'b1, b);
    chk("R9 byte before NACK", b, exp_rf[31][15:8]);
    lows = 0;
    sda_ctl = 1'b1;
    for (int k = 0; k < 9; k++) begin
      hstep();
      scl_ctl = 1'b1;
      repeat (H/2) @(negedge clk);
      if (!sda_line) lows++;
      repeat (H/2) @(negedge clk);
      scl_ctl = 1'b0;
    end
    bus_stop();
    chk("R9 SDA released after NACK", lows, 0);

    chk("R11 drive changed only with SCL low", oe_viol, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule